// File: doc/BRIEF.md
# Heap allocation range tracker

This block keeps a small table of the most recent dynamic memory allocations so that a cache can tell, on a store miss, whether the missing line holds nothing but uninitialized heap data. Each table entry covers a run of whole 64-byte cache blocks belonging to one allocation. It also holds a sweep pointer: the blocks below the pointer have already been written, and the block at the pointer is the next one to be initialized.

An allocation event supplies a byte base address and a byte size. The range is shrunk inward to whole blocks and written into the oldest slot. A miss lookup supplies a byte address and a store/load flag. One cycle later the block answers with either install or fetch. Install means the cache may create a zeroed line with no memory read. A store miss that hits the sweep block of the winning entry is installed, and that entry's pointer then moves up one block. When the pointer reaches the end of the range, the entry retires.

Top module: `heap_alloc_tracker`

## Requirements
- R1: While reset is asserted and after it is released, no entry is live: `rsp_valid` and `rsp_install` are 0 during reset, and any store miss after reset is answered with fetch until an allocation is recorded.
- R2: The tracked range of an allocation runs from the base rounded up to a 64-byte boundary, inclusive, to base+size rounded down to a 64-byte boundary, exclusive. A block that is only partly covered is never installed. An allocation that covers no whole block tracks nothing.
- R3: A store miss whose block (address bits above bit 5) equals the sweep block of the winning entry gets `rsp_install`=1, and the sweep block of that entry advances by one. A block is therefore installed at most once per allocation.
- R4: A store miss inside the winning entry's range but not at its sweep block gets fetch, and the sweep block does not move.
- R5: When the sweep block reaches the end of the range, the entry retires and matches no later lookup.
- R6: A load miss (`req_store`=0) always gets fetch and changes no entry.
- R7: When several live entries contain the block, only the most recently recorded one decides, even if an older one has its sweep block there.
- R8: The table holds 64 entries. Each new allocation overwrites the oldest one, so an allocation survives 63 later ones and is gone after the 64th.
- R9: `rsp_valid` is 1 exactly one cycle after a cycle with `req_en`=1, and `rsp_install` is 1 only together with `rsp_valid`.
- R10: When an allocation and a lookup occur in the same cycle, the lookup sees the table as it was before that allocation.
- R11: A store miss outside every live range gets fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously by the system |
| alloc_en | input | 1 | Record an allocation this cycle |
| alloc_base | input | ADDR_W | Byte address where the allocation starts |
| alloc_size | input | ADDR_W | Allocation length in bytes |
| req_en | input | 1 | Miss lookup this cycle |
| req_store | input | 1 | 1 = store miss, 0 = load miss |
| req_addr | input | ADDR_W | Byte address of the missing line |
| rsp_valid | output | 1 | Decision present (one cycle after the lookup) |
| rsp_install | output | 1 | 1 = install a zeroed line, 0 = fetch from memory |

## Verification
A small region is walked exhaustively. At every sweep position, stores to every other block inside the range, stores to the blocks just outside it, and a load at the sweep block are each tried before the store that advances the pointer. This separates a correct sweep comparison from a plain range test, and an inclusive end from an exclusive one. Unaligned allocations show whether the rounding goes inward. Overlapping allocations, whose older entry has its sweep block where the newer one does not, show whether the priority runs by age. A run of 63 and then 64 further allocations places the eviction boundary. Same-cycle allocation and lookup pairs show whether the lookup reads the table from before the write. A bench-side table model supplies every expected decision.

// File: rtl/heap_trk_pkg.sv
package heap_trk_pkg;

  typedef enum logic {
    DEC_FETCH   = 1'b0,
    DEC_INSTALL = 1'b1
  } miss_dec_e;

endpackage

// File: rtl/heap_trk_range_calc.sv
// Shrinks a byte range to whole cache blocks: start rounded up, end rounded down.
module heap_trk_range_calc #(
  parameter int ADDR_W  = 32,
  parameter int BLK_OFF = 6,
  parameter int BA_W    = ADDR_W + 1 - BLK_OFF
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  output logic [BA_W-1:0]   first_blk,
  output logic [BA_W-1:0]   end_blk,
  output logic              nonempty
);
  localparam logic [ADDR_W:0] BLK_MASK = (ADDR_W+1)'((1 << BLK_OFF) - 1);

  logic [ADDR_W:0] lo_sum;
  logic [ADDR_W:0] hi_sum;

  always_comb begin
    lo_sum    = {1'b0, base} + BLK_MASK;
    hi_sum    = {1'b0, base} + {1'b0, size};
    first_blk = BA_W'(lo_sum >> BLK_OFF);
    end_blk   = BA_W'(hi_sum >> BLK_OFF);
    nonempty  = end_blk > first_blk;
  end
endmodule

// File: rtl/heap_trk_entry.sv
// One tracked allocation: block range plus sweep pointer.
module heap_trk_entry #(
  parameter int BA_W = 27
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [BA_W-1:0] wr_first,
  input  logic [BA_W-1:0] wr_end,
  input  logic            wr_live,
  input  logic            adv_en,
  input  logic [BA_W-1:0] look_blk,
  output logic            live,
  output logic            in_range,
  output logic            at_sweep
);
  logic            live_q, live_d;
  logic [BA_W-1:0] first_q, first_d;
  logic [BA_W-1:0] end_q, end_d;
  logic [BA_W-1:0] sweep_q, sweep_d;
  logic [BA_W-1:0] sweep_inc;

  always_comb begin
    sweep_inc = sweep_q + 1'b1;
    live_d    = live_q;
    first_d   = first_q;
    end_d     = end_q;
    sweep_d   = sweep_q;
    if (wr_en) begin
      live_d  = wr_live;
      first_d = wr_first;
      end_d   = wr_end;
      sweep_d = wr_first;
    end else if (adv_en) begin
      sweep_d = sweep_inc;
      live_d  = (sweep_inc != end_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= live_d;
  end

  always_ff @(posedge clk) begin
    first_q <= first_d;
    end_q   <= end_d;
    sweep_q <= sweep_d;
  end

  assign live     = live_q;
  assign in_range = live_q && (look_blk >= first_q) && (look_blk < end_q);
  assign at_sweep = (look_blk == sweep_q);
endmodule

// File: rtl/heap_trk_select.sv
// Picks the newest matching entry, scanning backward from the most recent slot.
module heap_trk_select #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] match_vec,
  input  logic [IDX_W-1:0]   newest,
  output logic               found,
  output logic [IDX_W-1:0]   win_idx
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      int j;
      j = (int'(newest) - k + ENTRIES) % ENTRIES;
      if (!found && match_vec[j]) begin
        found   = 1'b1;
        win_idx = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/heap_alloc_tracker.sv
module heap_alloc_tracker
  import heap_trk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64,
  parameter int BLK_OFF = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_base,
  input  logic [ADDR_W-1:0] alloc_size,
  input  logic              req_en,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_install
);
  localparam int BA_W  = ADDR_W + 1 - BLK_OFF;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [BA_W-1:0]    new_first, new_end, req_blk;
  logic               new_nonempty;
  logic [IDX_W-1:0]   wr_ptr_q, wr_ptr_d, newest, win_idx;
  logic [ENTRIES-1:0] ent_live, ent_hit, ent_at_sweep;
  logic               found;
  miss_dec_e          dec_d, dec_q;
  logic               rsp_valid_q;

  heap_trk_range_calc #(.ADDR_W(ADDR_W), .BLK_OFF(BLK_OFF), .BA_W(BA_W)) range_i (
    .base(alloc_base), .size(alloc_size),
    .first_blk(new_first), .end_blk(new_end), .nonempty(new_nonempty)
  );

  assign req_blk = BA_W'({1'b0, req_addr} >> BLK_OFF);

  // Write pointer names the oldest slot; the slot before it is the newest.
  always_comb begin
    newest   = (wr_ptr_q == '0) ? LAST_IDX : wr_ptr_q - 1'b1;
    wr_ptr_d = wr_ptr_q;
    if (alloc_en) wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
  end

  heap_trk_select #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) sel_i (
    .match_vec(ent_hit), .newest(newest), .found(found), .win_idx(win_idx)
  );

  always_comb begin
    dec_d = DEC_FETCH;
    if (req_en && req_store && found && ent_at_sweep[win_idx]) dec_d = DEC_INSTALL;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic wr_here, adv_here;
    assign wr_here  = alloc_en && (wr_ptr_q == IDX_W'(i));
    assign adv_here = (dec_d == DEC_INSTALL) && (win_idx == IDX_W'(i));
    heap_trk_entry #(.BA_W(BA_W)) ent_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_here), .wr_first(new_first), .wr_end(new_end), .wr_live(new_nonempty),
      .adv_en(adv_here), .look_blk(req_blk),
      .live(ent_live[i]), .in_range(ent_hit[i]), .at_sweep(ent_at_sweep[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q    <= '0;
      rsp_valid_q <= 1'b0;
      dec_q       <= DEC_FETCH;
    end else begin
      wr_ptr_q    <= wr_ptr_d;
      rsp_valid_q <= req_en;
      dec_q       <= dec_d;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_install = (dec_q == DEC_INSTALL);

  logic unused_live;
  assign unused_live = ^ent_live;
endmodule

// File: rtl/heap_alloc_tracker_chk.sv
module heap_alloc_tracker_chk #(
  parameter int ADDR_W  = 32,
  parameter int BLK_OFF = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_en,
  input logic              req_en,
  input logic              req_store,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_install
);
  logic [ADDR_W:0] blk_full;
  assign blk_full = {1'b0, req_addr} >> BLK_OFF;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!rsp_valid && !rsp_install);
    end
  end

  a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_en |=> rsp_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_en |=> (!rsp_valid && !rsp_install));

  a_r6_load_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !req_store) |=> !rsp_install);

  a_r3_single_install: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_install && req_en && req_store && !$past(alloc_en) && (blk_full == $past(blk_full)))
      |=> !rsp_install);
endmodule

bind heap_alloc_tracker heap_alloc_tracker_chk #(.ADDR_W(ADDR_W), .BLK_OFF(BLK_OFF)) chk_i (
  .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .req_en(req_en), .req_store(req_store),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_install(rsp_install)
);

// File: tb/heap_alloc_tracker_tb_top.sv
`timescale 1ns/1ps
module heap_alloc_tracker_tb_top;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_en, req_en, req_store;
  logic [31:0] alloc_base, alloc_size, req_addr;
  logic        rsp_valid, rsp_install;

  int n_cmp = 0;
  int n_bad = 0;

  longint m_first[N], m_end[N], m_sweep[N];
  bit     m_live[N];
  int     m_wr;

  always #2 clk = ~clk;

  heap_alloc_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_base(alloc_base),
    .alloc_size(alloc_size), .req_en(req_en), .req_store(req_store), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_install(rsp_install)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < N; i++) m_live[i] = 0;
    m_wr = 0;
  endfunction

  // Newest containing entry decides; install only at its sweep block.
  function automatic bit model_lookup(input bit st, input longint addr);
    longint blk = addr >> 6;
    for (int k = 0; k < N; k++) begin
      int j = (m_wr - 1 - k + N) % N;
      if (m_live[j] && blk >= m_first[j] && blk < m_end[j]) begin
        if (st && m_sweep[j] == blk) begin
          m_sweep[j]++;
          if (m_sweep[j] == m_end[j]) m_live[j] = 0;
          return 1;
        end
        return 0;
      end
    end
    return 0;
  endfunction

  function automatic void model_alloc(input longint base, input longint size);
    longint f = (base + 63) >> 6;
    longint e = (base + size) >> 6;
    m_first[m_wr] = f;
    m_end[m_wr]   = e;
    m_sweep[m_wr] = f;
    m_live[m_wr]  = (e > f);
    m_wr = (m_wr + 1) % N;
  endfunction

  // Called at a falling edge; the response is checked at the next falling edge.
  task automatic cyc(input bit a_en, input longint a_base, input longint a_size,
                     input bit r_en, input bit r_st, input longint r_addr, input string tag);
    bit exp_i = 0;
    alloc_en   = a_en;
    alloc_base = 32'(a_base);
    alloc_size = 32'(a_size);
    req_en     = r_en;
    req_store  = r_st;
    req_addr   = 32'(r_addr);
    if (r_en) exp_i = model_lookup(r_st, r_addr);
    if (a_en) model_alloc(a_base, a_size);
    @(negedge clk);
    alloc_en = 0;
    req_en   = 0;
    chk(tag, {30'd0, rsp_valid, rsp_install}, {30'd0, r_en, exp_i});
  endtask

  task automatic alloc(input longint b, input longint s, input string tag);
    cyc(1, b, s, 0, 0, 0, tag);
  endtask

  task automatic store(input longint a, input string tag);
    cyc(0, 0, 0, 1, 1, a, tag);
  endtask

  task automatic load(input longint a, input string tag);
    cyc(0, 0, 0, 1, 0, a, tag);
  endtask

  task automatic expect_dec(input string tag, input bit exp);
    chk(tag, int'(rsp_install), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; alloc_en = 0; req_en = 0; req_store = 0;
    alloc_base = 0; alloc_size = 0; req_addr = 0;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {30'd0, rsp_valid, rsp_install}, 0);
    rst_n = 1;
    @(negedge clk);
    store(32'h1000, "R1 store after reset");
    expect_dec("R1 fetch after reset", 0);

    // R2: unaligned allocation covers blocks 0x41..0x43 only
    alloc(32'h1010, 32'h100, "R2 alloc");
    store(32'h1000, "R2 partial head block");
    expect_dec("R2 head fetch", 0);
    store(32'h1100, "R2 partial tail block");
    expect_dec("R2 tail fetch", 0);
    store(32'h1048, "R3 sweep 0x41");
    expect_dec("R3 install 0x41", 1);
    store(32'h1048, "R3 repeat 0x41");
    expect_dec("R3 repeat fetch", 0);
    store(32'h1080, "R3 sweep 0x42");
    store(32'h10C0, "R3 sweep 0x43");
    expect_dec("R3 install 0x43", 1);
    store(32'h10C0, "R5 retired entry");
    expect_dec("R5 fetch", 0);
    alloc(32'h2010, 32'h40, "R2 no whole block");
    store(32'h2040, "R2 empty alloc store");
    expect_dec("R2 empty fetch", 0);

    // Near-exhaustive walk over a 4-block region at blocks 0x1000..0x1003
    alloc(32'h40000, 32'h100, "R4 alloc");
    for (int s = 0; s < 4; s++) begin
      for (int b = -1; b <= 4; b++) begin
        if (b != s) begin
          store(32'h40000 + b * 64, "R4 off-sweep store");
          expect_dec("R4 off-sweep fetch", 0);
        end
      end
      load(32'h40000 + s * 64 + 4, "R6 load at sweep");
      expect_dec("R6 load fetch", 0);
      store(32'h40000 + s * 64 + 8, "R3 walk store");
      expect_dec("R3 walk install", 1);
    end
    store(32'h400C0, "R5 walk retired");
    expect_dec("R5 walk fetch", 0);
    store(32'h90000, "R11 untracked");
    expect_dec("R11 fetch", 0);

    // R7: older entry at sweep 0x2002; newer overlapping entry has sweep 0x2001
    alloc(32'h80000, 32'h400, "R7 alloc old");
    store(32'h80000, "R7 old sweep 0");
    store(32'h80040, "R7 old sweep 1");
    alloc(32'h80040, 32'hC0, "R7 alloc new");
    store(32'h80080, "R7 newer decides");
    expect_dec("R7 newer blocks older sweep", 0);
    store(32'h80040, "R7 newer sweep");
    expect_dec("R7 newer installs", 1);
    store(32'h80100, "R7 only older covers");
    expect_dec("R7 older alone", 0);
    store(32'h80080, "R7 newer second block");
    expect_dec("R7 newer install 2", 1);

    // R10: allocation and lookup in the same cycle
    cyc(1, 32'hA0000, 32'h80, 1, 1, 32'hA0000, "R10 same-cycle lookup");
    expect_dec("R10 old table fetch", 0);
    store(32'hA0000, "R10 next cycle");
    expect_dec("R10 now installs", 1);

    // R8: survives 63 later allocations, gone after 64
    alloc(32'h200000, 32'h80, "R8 alloc target");
    for (int i = 0; i < 63; i++) alloc(32'h300000 + i * 32'h1000, 32'h80, "R8 filler");
    store(32'h200000, "R8 after 63");
    expect_dec("R8 still tracked", 1);
    alloc(32'h400000, 32'h80, "R8 evicting alloc");
    store(32'h200040, "R8 after 64");
    expect_dec("R8 evicted fetch", 0);
    store(32'h400000, "R8 newest");
    expect_dec("R8 newest installs", 1);

    // R1: reset mid-run clears live entries
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset mid-run", {30'd0, rsp_valid, rsp_install}, 0);
    rst_n = 1;
    model_clear();
    @(negedge clk);
    store(32'h400040, "R1 entry cleared");
    expect_dec("R1 cleared fetch", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule